// File: doc/BRIEF.md
# Zoned TLB Translation Lookup

This block is the lookup half of a fully associative, software-managed translation buffer. Each cycle it can accept one request made of a 32-bit virtual address, an access kind (read, write or fetch) and a privilege flag (user or supervisor). It scans every entry's tag word, data word and process tag in parallel. Per entry it applies the page-size mask, the process-tag filter and a zone protection override. The lowest-numbered entry that survives all filters decides the outcome: a hit with a physical address, or a protection fault.

The entry contents arrive on flat array inputs, one 32-bit tag word, one 32-bit data word and one 8-bit process tag per entry. The zone protection word, the current process ID and the configuration (zones enabled, highest legal zone, physical address mask) are also inputs. Loading entries, the software register interface and page walking are outside this block. The response is registered and appears one clock after the request.

Top module: `tlbz_lookup`

## Requirements
- R1: For a request presented with `req_valid` high at a rising edge, `rsp_valid` is high after that edge and the result reflects the inputs sampled at that edge. After an edge with `req_valid` low, `rsp_valid` is low and `rsp_status`, `rsp_paddr`, `rsp_index` and `rsp_size` are all zero.
- R2: Tag bit 6 marks an entry valid. Tag bits 9:7 hold a size code c giving a page of 1 KiB << 2c bytes. An entry is a candidate only if it is valid and the virtual address equals the tag on every bit at position 10+2c and above.
- R3: An entry with a nonzero process tag is usable only when that tag equals `cur_pid`. A process tag of zero is usable under every `cur_pid`.
- R4: Data bits 7:4 select a zone z. The zone's 2-bit code is `zone_prot[31-2z:30-2z]`.
- R5: Zone code 0 removes the entry for a user access, and the search moves on to higher entries. For a supervisor access, code 0 behaves like code 1.
- R6: Zone code 1 uses the entry's own rights: data bit 8 grants write and data bit 9 grants fetch. Code 2 grants both rights to supervisor accesses and leaves user accesses on the entry's bits. Code 3 grants both rights to every access.
- R7: When `cfg_zones_en` is low, or the zone number is greater than `cfg_zone_max`, the zone code is taken as 1.
- R8: Only the lowest-index surviving entry is consulted. If the request is a write (`req_kind`=1) without write right, or a fetch (`req_kind`=2) without fetch right, `rsp_status` is 2 (fault). Reads (`req_kind`=0) never fault. Otherwise `rsp_status` is 1 (hit).
- R9: On a hit, `rsp_index` is the entry number and `rsp_size` is its size code. `rsp_paddr` = ((data & ~L) | (vaddr & L)) & `cfg_addr_mask`, where L = page size − 1.
- R10: On a miss (`rsp_status`=0, no survivor) `rsp_paddr`, `rsp_index` and `rsp_size` are zero. On a fault `rsp_paddr` is zero, and `rsp_index` and `rsp_size` name the faulting entry.
- R11: While `rst` is high at a rising edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| cur_pid | input | 8 | Current process ID |
| zone_prot | input | 32 | Sixteen 2-bit zone codes, zone 0 in the top bits |
| cfg_zones_en | input | 1 | Zone overrides enabled |
| cfg_zone_max | input | 4 | Highest zone number honoured |
| cfg_addr_mask | input | 32 | Mask applied to the physical address |
| ent_tag | input | NUM_ENTRIES*32 | Tag words, entry k at bits 32k+31:32k |
| ent_data | input | NUM_ENTRIES*32 | Data words, entry k at bits 32k+31:32k |
| ent_tid | input | NUM_ENTRIES*8 | Process tags, entry k at bits 8k+7:8k |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | 0 miss, 1 hit, 2 fault |
| rsp_paddr | output | 32 | Physical address on a hit |
| rsp_index | output | $clog2(NUM_ENTRIES) | Selected entry |
| rsp_size | output | 3 | Size code of the selected entry |

## Verification
Every result of this block is due exactly one rising edge after its request. The bench presents each request at a falling edge and reads the response at the next falling edge, which is the half-cycle after the single output register loads. Vectors follow back to back, so each response is checked before the next request is driven. The idle case is checked one falling edge after `req_valid` drops, and the reset state is checked at a falling edge while `rst` is held.

// File: rtl/tlbz_pkg.sv
package tlbz_pkg;

    localparam int VA_W        = 32;
    localparam int TID_W       = 8;
    localparam int TAG_VLD_BIT = 6;
    localparam int TAG_SZ_LO   = 7;
    localparam int ATTR_LO     = 4;   // data bits 9:4 carry ex, wr, zone
    localparam int ATTR_W      = 6;
    localparam int BASE_SHIFT  = 10;  // smallest page is 1 KiB

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        RES_MISS  = 2'd0,
        RES_HIT   = 2'd1,
        RES_FAULT = 2'd2
    } res_e;

    typedef struct packed {
        res_e            status;
        logic [VA_W-1:0] paddr;
        logic [2:0]      size;
    } rsp_core_t;

    // Offset bits inside a page of the given size code.
    function automatic logic [VA_W-1:0] page_lo_mask(input logic [2:0] code);
        return (32'h1 << (5'(BASE_SHIFT) + {1'b0, code, 1'b0})) - 32'd1;
    endfunction

    // Two-bit code of zone z, zone 0 in the topmost pair.
    function automatic logic [1:0] zone_field(input logic [31:0] zp,
                                              input logic [3:0]  z);
        logic [4:0] sh;
        sh = 5'd30 - {z, 1'b0};
        return 2'(zp >> sh);
    endfunction

endpackage

// File: rtl/tlbz_entry_eval.sv
module tlbz_entry_eval
    import tlbz_pkg::*;
(
    input  logic [VA_W-1:0]   tag,
    input  logic [ATTR_W-1:0] attr,       // {ex, wr, zone[3:0]}
    input  logic [TID_W-1:0]  tid,
    input  logic [VA_W-1:0]   vaddr,
    input  logic              user,
    input  logic [TID_W-1:0]  pid,
    input  logic [31:0]       zone_prot,
    input  logic              zones_en,
    input  logic [3:0]        zone_max,
    output logic              survive,
    output logic              wr_eff,
    output logic              ex_eff
);

    logic [VA_W-1:0] lo;
    logic [3:0]      zsel;
    logic [1:0]      zcode;
    logic            addr_hit;
    logic            pid_hit;
    logic            force_all;

    always_comb begin
        lo       = page_lo_mask(tag[TAG_SZ_LO +: 3]);
        addr_hit = ((vaddr ^ tag) & ~lo) == '0;
        pid_hit  = (tid == '0) || (tid == pid);
        zsel     = attr[3:0];
        if (!zones_en || (zsel > zone_max))
            zcode = 2'd1;
        else
            zcode = zone_field(zone_prot, zsel);
        force_all = (zcode == 2'd3) || ((zcode == 2'd2) && !user);
        wr_eff    = attr[4] | force_all;
        ex_eff    = attr[5] | force_all;
        survive   = tag[TAG_VLD_BIT] && addr_hit && pid_hit
                    && !((zcode == 2'd0) && user);
    end

endmodule

// File: rtl/tlbz_first_hit.sv
module tlbz_first_hit #(
    parameter  int N     = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlbz_lookup.sv
module tlbz_lookup
    import tlbz_pkg::*;
#(
    parameter  int NUM_ENTRIES = 64,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [31:0]                  req_vaddr,
    input  logic [1:0]                   req_kind,
    input  logic                         req_user,
    input  logic [7:0]                   cur_pid,
    input  logic [31:0]                  zone_prot,
    input  logic                         cfg_zones_en,
    input  logic [3:0]                   cfg_zone_max,
    input  logic [31:0]                  cfg_addr_mask,
    input  logic [NUM_ENTRIES*32-1:0]    ent_tag,
    input  logic [NUM_ENTRIES*32-1:0]    ent_data,
    input  logic [NUM_ENTRIES*8-1:0]     ent_tid,
    output logic                         rsp_valid,
    output logic [1:0]                   rsp_status,
    output logic [31:0]                  rsp_paddr,
    output logic [IDX_W-1:0]             rsp_index,
    output logic [2:0]                   rsp_size
);

    logic [NUM_ENTRIES-1:0] surv_v;
    logic [NUM_ENTRIES-1:0] wr_v;
    logic [NUM_ENTRIES-1:0] ex_v;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        tlbz_entry_eval u_eval (
            .tag       (ent_tag[g*VA_W +: VA_W]),
            .attr      (ent_data[g*VA_W + ATTR_LO +: ATTR_W]),
            .tid       (ent_tid[g*TID_W +: TID_W]),
            .vaddr     (req_vaddr),
            .user      (req_user),
            .pid       (cur_pid),
            .zone_prot (zone_prot),
            .zones_en  (cfg_zones_en),
            .zone_max  (cfg_zone_max),
            .survive   (surv_v[g]),
            .wr_eff    (wr_v[g]),
            .ex_eff    (ex_v[g])
        );
    end

    logic             found;
    logic [IDX_W-1:0] sel_idx;

    tlbz_first_hit #(.N(NUM_ENTRIES)) u_pick (
        .vec   (surv_v),
        .found (found),
        .idx   (sel_idx)
    );

    acc_e             kind;
    logic [VA_W-1:0]  sel_data;
    logic [2:0]       sel_size;
    logic [VA_W-1:0]  lo;
    logic             denied;
    rsp_core_t        nxt_core;
    logic [IDX_W-1:0] nxt_idx;
    rsp_core_t        core_q;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        kind     = acc_e'(req_kind);
        sel_data = ent_data[int'(sel_idx)*VA_W +: VA_W];
        sel_size = ent_tag[int'(sel_idx)*VA_W + TAG_SZ_LO +: 3];
        lo       = page_lo_mask(sel_size);
        denied   = ((kind == ACC_WRITE) && !wr_v[sel_idx])
                || ((kind == ACC_FETCH) && !ex_v[sel_idx]);
        nxt_core = '{status: RES_MISS, paddr: '0, size: '0};
        nxt_idx  = '0;
        if (req_valid && found) begin
            nxt_idx       = sel_idx;
            nxt_core.size = sel_size;
            if (denied) begin
                nxt_core.status = RES_FAULT;
            end else begin
                nxt_core.status = RES_HIT;
                nxt_core.paddr  = ((sel_data & ~lo) | (req_vaddr & lo))
                                  & cfg_addr_mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            core_q    <= '{status: RES_MISS, paddr: '0, size: '0};
            idx_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            core_q    <= nxt_core;
            idx_q     <= nxt_idx;
        end
    end

    assign rsp_status = core_q.status;
    assign rsp_paddr  = core_q.paddr;
    assign rsp_size   = core_q.size;
    assign rsp_index  = idx_q;

endmodule

// File: rtl/tlbz_lookup_chk.sv
module tlbz_lookup_chk
    import tlbz_pkg::*;
#(
    parameter  int NUM_ENTRIES = 64,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic [31:0]      req_vaddr,
    input logic [31:0]      cfg_addr_mask,
    input logic             rsp_valid,
    input logic [1:0]       rsp_status,
    input logic [31:0]      rsp_paddr,
    input logic [IDX_W-1:0] rsp_index,
    input logic [2:0]       rsp_size
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_status == 2'd0 && rsp_paddr == '0)); // R1

    AST_READ_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd0) |=> (rsp_status != 2'd2)); // R8

    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rsp_status == 2'd0) |-> (rsp_paddr == '0 && rsp_index == '0 && rsp_size == '0)); // R10

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rsp_status == 2'd2) |-> (rsp_paddr == '0)); // R10

    AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd1) |->
        (((rsp_paddr ^ ($past(req_vaddr) & $past(cfg_addr_mask)))
          & page_lo_mask(rsp_size)) == '0)); // R9

endmodule

bind tlbz_lookup tlbz_lookup_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_vaddr     (req_vaddr),
    .cfg_addr_mask (cfg_addr_mask),
    .rsp_valid     (rsp_valid),
    .rsp_status    (rsp_status),
    .rsp_paddr     (rsp_paddr),
    .rsp_index     (rsp_index),
    .rsp_size      (rsp_size)
);

// File: tb/tlbz_lookup_test.sv
module tlbz_lookup_test;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 64;
    localparam int IW         = $clog2(N);

    logic             clk = 1'b0;
    logic             rst;
    logic             req_valid;
    logic [31:0]      req_vaddr;
    logic [1:0]       req_kind;
    logic             req_user;
    logic [7:0]       cur_pid;
    logic [31:0]      zone_prot;
    logic             cfg_zones_en;
    logic [3:0]       cfg_zone_max;
    logic [31:0]      cfg_addr_mask;
    logic [N*32-1:0]  ent_tag;
    logic [N*32-1:0]  ent_data;
    logic [N*8-1:0]   ent_tid;
    logic             rsp_valid;
    logic [1:0]       rsp_status;
    logic [31:0]      rsp_paddr;
    logic [IW-1:0]    rsp_index;
    logic [2:0]       rsp_size;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbz_lookup #(.NUM_ENTRIES(N)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .cur_pid(cur_pid),
        .zone_prot(zone_prot), .cfg_zones_en(cfg_zones_en),
        .cfg_zone_max(cfg_zone_max), .cfg_addr_mask(cfg_addr_mask),
        .ent_tag(ent_tag), .ent_data(ent_data), .ent_tid(ent_tid),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr),
        .rsp_index(rsp_index), .rsp_size(rsp_size)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  kind;
        logic        user;
        logic [7:0]  pid;
        logic [31:0] zp;
        logic        zen;
        logic [3:0]  zmax;
        logic [31:0] amask;
        logic [1:0]  st;
        logic [31:0] pa;
        logic [5:0]  idx;
        logic [2:0]  sz;
        logic [3:0]  rq;
    } vec_t;

    // kind: 0 read, 1 write, 2 fetch; st: 0 miss, 1 hit, 2 fault
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1234, 2'd0, 1'b0, 8'd5, 32'h5555_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd1, 32'h8000_0234, 6'd0,  3'd1, 4'd9},  // R9
        '{32'h0000_1234, 2'd1, 1'b1, 8'd5, 32'h5555_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd2, 32'h0,         6'd0,  3'd1, 4'd8},  // R8
        '{32'h0000_1FFC, 2'd2, 1'b1, 8'd5, 32'h5555_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd2, 32'h0,         6'd0,  3'd1, 4'd8},  // R8
        '{32'h0012_3456, 2'd1, 1'b1, 8'd5, 32'h5555_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd1, 32'h0202_3456, 6'd1,  3'd5, 4'd3},  // R3
        '{32'h0012_3456, 2'd1, 1'b1, 8'd6, 32'h5555_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd2, 32'h0,         6'd2,  3'd5, 4'd3},  // R3
        '{32'h0012_3456, 2'd1, 1'b0, 8'd6, 32'h5955_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd1, 32'h0302_3456, 6'd2,  3'd5, 4'd6},  // R6
        '{32'h0012_3456, 2'd1, 1'b1, 8'd6, 32'h5955_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd2, 32'h0,         6'd2,  3'd5, 4'd6},  // R6
        '{32'h0012_3456, 2'd0, 1'b1, 8'd6, 32'h5155_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd0, 32'h0,         6'd0,  3'd0, 4'd5},  // R5
        '{32'h0012_3456, 2'd0, 1'b0, 8'd6, 32'h5155_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd1, 32'h0302_3456, 6'd2,  3'd5, 4'd5},  // R5
        '{32'h0012_3456, 2'd0, 1'b1, 8'd6, 32'h5155_5555, 1'b0, 4'd15, 32'hFFFF_FFFF, 2'd1, 32'h0302_3456, 6'd2,  3'd5, 4'd7},  // R7
        '{32'h0012_3456, 2'd0, 1'b1, 8'd6, 32'h5155_5555, 1'b1, 4'd1,  32'hFFFF_FFFF, 2'd1, 32'h0302_3456, 6'd2,  3'd5, 4'd7},  // R7
        '{32'h0012_3456, 2'd0, 1'b1, 8'd6, 32'h5155_5555, 1'b1, 4'd2,  32'hFFFF_FFFF, 2'd0, 32'h0,         6'd0,  3'd0, 4'd7},  // R7
        '{32'h0040_0123, 2'd2, 1'b1, 8'd5, 32'h5555_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd1, 32'h0000_4523, 6'd3,  3'd0, 4'd2},  // R2
        '{32'h0040_0123, 2'd1, 1'b1, 8'd5, 32'h5555_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd2, 32'h0,         6'd3,  3'd0, 4'd8},  // R8
        '{32'h0040_0923, 2'd1, 1'b1, 8'd5, 32'h5555_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd1, 32'h0050_0923, 6'd5,  3'd2, 4'd2},  // R2
        '{32'h0040_0123, 2'd1, 1'b1, 8'd5, 32'h5755_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd1, 32'h0000_4523, 6'd3,  3'd0, 4'd4},  // R4
        '{32'hFF12_3456, 2'd0, 1'b1, 8'd5, 32'h5555_5555, 1'b1, 4'd15, 32'h0FFF_FFFF, 2'd1, 32'h0F12_3456, 6'd63, 3'd7, 4'd9},  // R9
        '{32'hFF00_0000, 2'd2, 1'b0, 8'd5, 32'h5555_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd2, 32'h0,         6'd63, 3'd7, 4'd10}, // R10
        '{32'h2000_0000, 2'd0, 1'b0, 8'd5, 32'h5555_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd0, 32'h0,         6'd0,  3'd0, 4'd10}, // R10
        '{32'h0000_2000, 2'd0, 1'b0, 8'd5, 32'h5555_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd0, 32'h0,         6'd0,  3'd0, 4'd2},  // R2
        '{32'hFF00_0010, 2'd2, 1'b0, 8'd5, 32'h5595_5555, 1'b1, 4'd15, 32'hFFFF_FFFF, 2'd1, 32'h1F00_0010, 6'd63, 3'd7, 4'd6}   // R6
    };

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    task automatic put_entry(input int k, input logic [31:0] tag,
                             input logic [31:0] data, input logic [7:0] tid);
        ent_tag[k*32 +: 32] = tag;
        ent_data[k*32 +: 32] = data;
        ent_tid[k*8 +: 8]   = tid;
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
        req_user = 1'b0; cur_pid = '0; zone_prot = '0; cfg_zones_en = 1'b0;
        cfg_zone_max = '0; cfg_addr_mask = '0;
        ent_tag = '0; ent_data = '0; ent_tid = '0;
        // tag = page | size<<7 | valid<<6; data = rpn | ex<<9 | wr<<8 | zone<<4
        put_entry(0,  32'h0000_10C0, 32'h8000_0000, 8'd0);  // 4K, no rights, zone 0
        put_entry(1,  32'h0010_02C0, 32'h0200_0310, 8'd5);  // 1M, wr+ex, zone 1, pid 5
        put_entry(2,  32'h0010_02C0, 32'h0300_0020, 8'd0);  // 1M, no rights, zone 2
        put_entry(3,  32'h0040_0040, 32'h0000_4630, 8'd0);  // 1K, ex only, zone 3
        put_entry(5,  32'h0040_0140, 32'h0050_03F0, 8'd0);  // 16K, wr+ex, zone 15
        put_entry(10, 32'h2000_0000, 32'h1234_5300, 8'd0);  // not valid
        put_entry(63, 32'hFF00_03C0, 32'h1F00_0140, 8'd0);  // 16M, wr only, zone 4

        repeat (3) @(negedge clk);
        // R11: outputs cleared under reset
        chk(11, "reset rsp_valid",  32'(rsp_valid),  32'd0);
        chk(11, "reset rsp_status", 32'(rsp_status), 32'd0);
        chk(11, "reset rsp_paddr",  rsp_paddr,       32'd0);
        chk(11, "reset rsp_index",  32'(rsp_index),  32'd0);
        chk(11, "reset rsp_size",   32'(rsp_size),   32'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            req_valid     = 1'b1;
            req_vaddr     = VECS[k].va;
            req_kind      = VECS[k].kind;
            req_user      = VECS[k].user;
            cur_pid       = VECS[k].pid;
            zone_prot     = VECS[k].zp;
            cfg_zones_en  = VECS[k].zen;
            cfg_zone_max  = VECS[k].zmax;
            cfg_addr_mask = VECS[k].amask;
            @(negedge clk);
            chk(1, $sformatf("vec%0d rsp_valid", k), 32'(rsp_valid), 32'd1); // R1
            chk(int'(VECS[k].rq), $sformatf("vec%0d status", k), 32'(rsp_status), 32'(VECS[k].st));
            chk(int'(VECS[k].rq), $sformatf("vec%0d paddr", k),  rsp_paddr,        VECS[k].pa);
            chk(int'(VECS[k].rq), $sformatf("vec%0d index", k),  32'(rsp_index),  32'(VECS[k].idx));
            chk(int'(VECS[k].rq), $sformatf("vec%0d size", k),   32'(rsp_size),   32'(VECS[k].sz));
        end

        // R1: idle cycle clears the response
        req_valid = 1'b0;
        @(negedge clk);
        chk(1, "idle rsp_valid",  32'(rsp_valid),  32'd0);
        chk(1, "idle rsp_status", 32'(rsp_status), 32'd0);
        chk(1, "idle rsp_paddr",  rsp_paddr,       32'd0);

        // R11: reset after a hit clears the held result
        req_valid = 1'b1; req_vaddr = 32'h0000_1234; req_kind = 2'd0;
        req_user = 1'b0; zone_prot = 32'h5555_5555; cfg_zones_en = 1'b1;
        cfg_zone_max = 4'd15; cfg_addr_mask = 32'hFFFF_FFFF;
        @(negedge clk);
        chk(9, "pre-reset paddr", rsp_paddr, 32'h8000_0234);
        rst = 1'b1;
        @(negedge clk);
        chk(11, "mid reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk(11, "mid reset rsp_paddr", rsp_paddr,       32'd0);
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule